// File: doc/BRIEF.md
# Variable-Count Bit Stream Compactor

This block takes a stream of 32-bit beats in which each beat carries a side-band count. The count says how many of the low-order data bits are meaningful. The block keeps only those bits and joins them end to end into dense 32-bit words. Bit 0 of every beat is the earliest bit in symbol order, and the kept bits continue upward from there. Each finished word is presented on a one-word write port toward a symbol store that is split into two halves.

A symbol is complete when the accepted bit count reaches a configured length, or when the beat that closes a packet arrives. At that point the block does three things:

- It writes any partial word, padded with zeros.
- It marks that half as ready for the reader.
- It moves on to the other half.

The reader hands a half back with a one-cycle release pulse. While the half that is due to be filled still belongs to the reader, the input is held off, so no beat is lost.

Top module: `bit_compactor`

## Requirements
- R1: After reset, s_tready is 1, sym_ready is 2'b00, wr_en is 0, and the first symbol goes to half 0.
- R2: The kept bits of accepted beats are appended in arrival order. Beat bit k goes to the next free position, and word bit 0 is the earliest. Once 32 bits are pending, the word appears on wr_data with wr_en high for one cycle, in the cycle after the accepting clock edge.
- R3: A count value from 33 to 63 on s_tuser is treated as 32.
- R4: wr_addr has the half number in its most significant bit and the word index in the bits below it. The index starts at 0 for each symbol and rises by one with each write.
- R5: A symbol ends when the accepted bits reach cfg_sym_bits (1 to 32*MAX_WORDS). The remaining bits are written as a final word with zeros above them. sym_ready for that half rises in the same cycle as the last write. The next symbol fills the other half.
- R6: When a beat would carry the count past cfg_sym_bits, only the bits up to the symbol length are kept and the rest of that beat is dropped.
- R7: A beat with s_tlast high ends the symbol after its bits are taken, even when the count is below cfg_sym_bits.
- R8: A beat with count 0 is accepted and produces no write. It adds no bit to the word or to the symbol count.
- R9: s_tready is 0 while the half to be filled has sym_ready set. A beat held during that time is taken intact once the half is released.
- R10: A pulse on sym_done[i] clears sym_ready[i] on the next clock edge.
- R11: If the closing beat leaves more than 32 bits pending, two writes follow on consecutive cycles. s_tready is 0 in the cycle that produces the second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sym_bits | input | SYMB_W | Symbol length in bits |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted when high together with valid |
| s_tdata | input | 32 | Beat data, meaningful bits from bit 0 upward |
| s_tuser | input | USER_W | Count of meaningful bits in the beat |
| s_tlast | input | 1 | Ends the current symbol after this beat |
| wr_en | output | 1 | Store write strobe |
| wr_addr | output | IDX_W+1 | Store word address {half, index} |
| wr_data | output | 32 | Packed word |
| sym_ready | output | 2 | Per-half symbol complete, owned by the reader |
| sym_done | input | 2 | Per-half release pulse from the reader |

## Verification
The bench builds the block with MAX_WORDS set to 8, which limits a symbol to 256 bits. That size makes full-length symbols, the top word index and repeated alternation between halves reachable in a few dozen beats. The count width stays at its default of 6 bits, so the bench can drive the out-of-range counts 33 to 63 on the port. A bit-queue model predicts every write address and word, and short symbols let the bench fill both halves and hold a beat back while the input is stalled.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int WORD_W = 32;
    localparam int ACC_W  = 2 * WORD_W;
    localparam int PEND_W = $clog2(ACC_W) + 1;
    localparam int TAKE_W = $clog2(WORD_W) + 1;
endpackage

// File: rtl/cmp_take.sv
module cmp_take
    import cmp_pkg::*;
#(
    parameter int USER_W = 6,
    parameter int ROOM_W = 14
) (
    input  logic [USER_W-1:0] cnt_i,
    input  logic [ROOM_W-1:0] room_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [TAKE_W-1:0] take_o,
    output logic [WORD_W-1:0] bits_o
);
    logic [31:0] n_w;
    logic [31:0] r_w;
    logic [31:0] t_w;
    logic [WORD_W-1:0] mask_w;

    always_comb begin
        // clamp the side-band count to one word, then to what the symbol still holds
        n_w = 32'(cnt_i);
        if (n_w > 32'(WORD_W)) n_w = 32'(WORD_W);
        r_w = 32'(room_i);
        t_w = (n_w > r_w) ? r_w : n_w;
        if (t_w >= 32'(WORD_W)) mask_w = '1;
        else                    mask_w = (WORD_W'(1) << t_w) - WORD_W'(1);
        take_o = TAKE_W'(t_w);
        bits_o = data_i & mask_w;
    end
endmodule

// File: rtl/cmp_owner.sv
module cmp_owner (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  logic       set_sel,
    input  logic [1:0] done_i,
    output logic [1:0] ready_o
);
    logic [1:0] ready_d, ready_q;

    always_comb begin
        ready_d = ready_q & ~done_i;
        if (set_en) ready_d[set_sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= '0;
        else        ready_q <= ready_d;
    end

    assign ready_o = ready_q;
endmodule

// File: rtl/bit_compactor.sv
module bit_compactor
    import cmp_pkg::*;
#(
    parameter int MAX_WORDS = 384,
    parameter int USER_W    = 6,
    localparam int IDX_W    = $clog2(MAX_WORDS),
    localparam int ADDR_W   = IDX_W + 1,
    localparam int SYMB_W   = $clog2(MAX_WORDS * WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYMB_W-1:0] cfg_sym_bits,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [WORD_W-1:0] s_tdata,
    input  logic [USER_W-1:0] s_tuser,
    input  logic              s_tlast,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [1:0]        sym_ready,
    input  logic [1:0]        sym_done
);
    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [PEND_W-1:0] pend;
        logic [SYMB_W-1:0] cnt;
        logic [IDX_W-1:0]  idx;
        logic              half;
        logic              flush;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [WORD_W-1:0] wr_data;
    } st_t;

    st_t st_d, st_q;

    logic [SYMB_W-1:0] room;
    logic [TAKE_W-1:0] take;
    logic [WORD_W-1:0] kept;
    logic              set_en;
    logic [1:0]        ready;
    logic              accept;
    logic [ACC_W-1:0]  acc_n;
    logic [PEND_W-1:0] pend_n;
    logic [SYMB_W-1:0] cnt_n;
    logic              fin;

    assign room = (cfg_sym_bits > st_q.cnt) ? (cfg_sym_bits - st_q.cnt) : '0;

    cmp_take #(.USER_W(USER_W), .ROOM_W(SYMB_W)) u_take (
        .cnt_i  (s_tuser),
        .room_i (room),
        .data_i (s_tdata),
        .take_o (take),
        .bits_o (kept)
    );

    cmp_owner u_owner (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_sel (st_q.half),
        .done_i  (sym_done),
        .ready_o (ready)
    );

    assign s_tready = !st_q.flush && !ready[st_q.half];
    assign accept   = s_tvalid && s_tready;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        set_en     = 1'b0;
        acc_n      = st_q.acc | ({{WORD_W{1'b0}}, kept} << st_q.pend);
        pend_n     = st_q.pend + PEND_W'(take);
        cnt_n      = st_q.cnt + SYMB_W'(take);
        fin        = s_tlast || (cnt_n >= cfg_sym_bits);

        if (st_q.flush) begin
            // second word of a closing beat; input is held this cycle
            st_d.wr_en   = 1'b1;
            st_d.wr_addr = {st_q.half, st_q.idx};
            st_d.wr_data = st_q.acc[WORD_W-1:0];
            st_d.acc     = '0;
            st_d.pend    = '0;
            st_d.flush   = 1'b0;
            st_d.cnt     = '0;
            st_d.idx     = '0;
            st_d.half    = ~st_q.half;
            set_en       = 1'b1;
        end else if (accept) begin
            st_d.cnt = cnt_n;
            if (pend_n >= PEND_W'(WORD_W) || (fin && pend_n != '0)) begin
                st_d.wr_en   = 1'b1;
                st_d.wr_addr = {st_q.half, st_q.idx};
                st_d.wr_data = acc_n[WORD_W-1:0];
                st_d.idx     = st_q.idx + IDX_W'(1);
            end
            if (pend_n >= PEND_W'(WORD_W)) begin
                st_d.acc  = acc_n >> WORD_W;
                st_d.pend = pend_n - PEND_W'(WORD_W);
            end else if (fin) begin
                st_d.acc  = '0;
                st_d.pend = '0;
            end else begin
                st_d.acc  = acc_n;
                st_d.pend = pend_n;
            end
            if (fin) begin
                if (pend_n > PEND_W'(WORD_W)) begin
                    st_d.flush = 1'b1;
                end else begin
                    st_d.cnt  = '0;
                    st_d.idx  = '0;
                    st_d.half = ~st_q.half;
                    set_en    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en     = st_q.wr_en;
    assign wr_addr   = st_q.wr_addr;
    assign wr_data   = st_q.wr_data;
    assign sym_ready = ready;
endmodule

// File: rtl/bit_compactor_chk.sv
module bit_compactor_chk #(
    parameter int MAX_WORDS = 384,
    localparam int IDX_W    = $clog2(MAX_WORDS),
    localparam int ADDR_W   = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        sym_ready,
    input logic [1:0]        sym_done
);
    assert_stall_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_ready == 2'b11) |-> !s_tready);

    assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr[IDX_W-1:0]) < 32'(MAX_WORDS)));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sym_done & sym_ready)) |=> ((sym_ready & $past(sym_done & sym_ready)) == 2'b00));

    assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sym_ready & ~$past(sym_ready)));

    assert_write_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(s_tvalid && s_tready) || ($past(wr_en) && !$past(s_tready))));
endmodule

bind bit_compactor bit_compactor_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_tvalid  (s_tvalid),
    .s_tready  (s_tready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .sym_ready (sym_ready),
    .sym_done  (sym_done)
);

// File: tb/tb_bit_compactor.sv
`timescale 1ns/1ps
module tb_bit_compactor;
    localparam int MAXW   = 8;
    localparam int USER_W = 6;
    localparam int IDX_W  = $clog2(MAXW);
    localparam int ADDR_W = IDX_W + 1;
    localparam int SYMB_W = $clog2(MAXW * 32 + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SYMB_W-1:0] cfg_sym_bits = '0;
    logic              s_tvalid = 1'b0;
    logic              s_tready;
    logic [31:0]       s_tdata = '0;
    logic [USER_W-1:0] s_tuser = '0;
    logic              s_tlast = 1'b0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic [1:0]        sym_ready;
    logic [1:0]        sym_done = '0;

    always #2 clk = ~clk;

    bit_compactor #(.MAX_WORDS(MAXW), .USER_W(USER_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_sym_bits(cfg_sym_bits),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .s_tuser(s_tuser), .s_tlast(s_tlast), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sym_ready(sym_ready),
        .sym_done(sym_done)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // reference model state
    bit                   mbits[$];
    int                   mcnt = 0;
    bit                   mhalf = 1'b0;
    int                   midx = 0;
    bit [1:0]             mready = 2'b00;
    logic [ADDR_W+31:0]   expq[$];
    logic [31:0]          seed = 32'h1234_5678;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic emit_word();
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 32; k++) w[k] = mbits.pop_front();
        expq.push_back({mhalf, IDX_W'(midx), w});
        midx++;
    endtask

    task automatic model_beat(input logic [31:0] d, input int n, input bit l);
        int t;
        t = (n > 32) ? 32 : n;
        if (t > int'(cfg_sym_bits) - mcnt) t = int'(cfg_sym_bits) - mcnt;
        for (int k = 0; k < t; k++) mbits.push_back(d[k]);
        mcnt += t;
        while (mbits.size() >= 32) emit_word();
        if (l || mcnt >= int'(cfg_sym_bits)) begin
            if (mbits.size() > 0) begin
                while (mbits.size() < 32) mbits.push_back(1'b0);
                emit_word();
            end
            mready[mhalf] = 1'b1;
            mhalf = ~mhalf;
            midx = 0;
            mcnt = 0;
        end
    endtask

    task automatic send(input logic [31:0] d, input int n, input bit l);
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = d;
        s_tuser  = USER_W'(n);
        s_tlast  = l;
        while (!s_tready) @(negedge clk);
        model_beat(d, n, l);
        @(posedge clk);
        #1;
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic release_half(input int i);
        @(negedge clk);
        sym_done[i] = 1'b1;
        @(negedge clk);
        sym_done[i] = 1'b0;
        mready[i] = 1'b0;
        check("R10", 64'(sym_ready[i]), 64'd0, "ready after release");
    endtask

    task automatic idle_check_ready(input string req);
        repeat (3) @(negedge clk);
        check(req, 64'(sym_ready), 64'(mready), "sym_ready");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (expq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL %s unexpected write: actual=%0h expected=none", cur_req, {wr_addr, wr_data});
            end else begin
                logic [ADDR_W+31:0] e;
                e = expq.pop_front();
                check(cur_req, 64'({wr_addr, wr_data}), 64'(e), "write addr/data");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 64'(s_tready), 64'd1, "tready after reset");
        check("R1", 64'(sym_ready), 64'd0, "sym_ready after reset");
        check("R1", 64'(wr_en), 64'd0, "wr_en after reset");

        // R2 R5: whole words, symbol of exactly two words in half 0
        cur_req = "R2 R5";
        cfg_sym_bits = SYMB_W'(64);
        send(32'hA5A5_0F0F, 32, 1'b0);
        send(32'h3C3C_9669, 32, 1'b0);
        idle_check_ready("R5");
        check("R2", 64'(expq.size()), 64'd0, "pending expected writes");
        release_half(0);

        // R3 R6 R8: mixed counts, zero-count beat, oversized count, crossing beat
        cur_req = "R3 R6 R8";
        cfg_sym_bits = SYMB_W'(100);
        send(32'hFFFF_FF55, 7, 1'b0);
        send(32'h1234_5ABC, 13, 1'b0);
        send(32'hFFFF_FFFF, 0, 1'b0);
        @(negedge clk);
        check("R8", 64'(wr_en), 64'd0, "no write after zero-count beat");
        send(32'hDEAD_BEEF, 32, 1'b0);
        send(32'h0000_0001, 1, 1'b0);
        send(32'hCAFE_F00D, 20, 1'b0);
        send(32'h8765_4321, 40, 1'b0);
        idle_check_ready("R6");

        // R7: early end by the last flag, half 0
        cur_req = "R7";
        cfg_sym_bits = SYMB_W'(200);
        send(32'h0000_03A5, 10, 1'b0);
        send(32'h0000_0017, 5, 1'b1);
        idle_check_ready("R7");

        // R9: both halves owned by the reader, beat must wait
        cur_req = "R9";
        check("R9", 64'(s_tready), 64'd0, "tready while half 1 owned");
        fork
            send(32'h7FFF_1234, 31, 1'b0);
            begin
                repeat (4) begin
                    @(negedge clk);
                    check("R9", 64'(s_tready), 64'd0, "tready stalled");
                    check("R9", 64'(wr_en), 64'd0, "no write while stalled");
                end
                release_half(1);
            end
        join

        // R11: closing beat leaves 63 bits pending
        cur_req = "R11";
        send(32'h9ABC_DEF1, 32, 1'b1);
        @(negedge clk);
        check("R11", 64'(wr_en), 64'd1, "first closing write");
        check("R11", 64'(s_tready), 64'd0, "tready during flush");
        @(negedge clk);
        check("R11", 64'(wr_en), 64'd1, "second closing write");
        check("R11", 64'(sym_ready), 64'(mready), "ready with last write");
        release_half(0);
        release_half(1);

        // R4: full-length symbol, every word index, crossing at the end
        cur_req = "R4";
        cfg_sym_bits = SYMB_W'(MAXW * 32);
        for (int b = 0; b < 11; b++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            send(seed, 24, 1'b0);
        end
        idle_check_ready("R4");
        release_half(0);

        // R2 R3: pseudo-random counts over several symbols
        cur_req = "R2 R3";
        cfg_sym_bits = SYMB_W'(97);
        for (int s = 0; s < 3; s++) begin
            bit h;
            h = mhalf;
            while (!mready[h]) begin
                logic [31:0] d;
                seed = seed * 32'd1664525 + 32'd1013904223;
                d = seed;
                seed = seed * 32'd1664525 + 32'd1013904223;
                send(d, int'(seed[29:24]), 1'b0);
            end
            idle_check_ready("R5");
            release_half(int'(h));
        end

        repeat (5) @(negedge clk);
        check("R2", 64'(expq.size()), 64'd0, "all expected writes seen");
        report();
    end
endmodule